// File: doc/BRIEF.md
# Embedded Program/Erase Operation Controller

This block runs the internal byte-program and whole-array erase algorithms of a flash-style memory after a command decoder has accepted the command. The decoder gives a one-cycle start request with the operation type, the target address and the target data. The controller then drives a simple array port with byte writes, a whole-array erase strobe and address-indexed reads, and checks its own work after each write. The array port reads combinationally: the read data is valid in the same cycle as the address.

While an operation runs, and after it fails, the data read port returns a status byte instead of array contents. The status byte carries three bits. The top bit is a polling bit. The next bit flips on every status read. The third bit flags that the time limit has expired. The time limits count ticks of an external `tick_i` strobe, with one limit for programming and a separate one for erasing. Programming can only clear bits. A request that would need a 0 turned into a 1 keeps retrying until the program limit expires. An erase first writes zeros to every byte and checks each one, then pulses the erase strobe and checks that every byte reads all ones.

Top module: `emb_op_ctrl`

## Requirements
- R1: After reset and whenever `busy_o` is low, the block is in read mode: `rd_data_o` shows the array byte at `rd_addr_i`, and the array is neither written nor erased.
- R2: A `start_i` pulse in read mode raises `busy_o` on the next clock edge. While an operation runs, `start_i` and `reset_cmd_i` have no effect.
- R3: While a program runs, `rd_data_o[7]` reads as the complement of bit 7 of the target data, and `rd_data_o[4:0]` read 0. After the program completes, a read of the target address returns the target data.
- R4: While `busy_o` is high, `rd_data_o[6]` takes the opposite value on each successive read strobe (`rd_i`). This holds while the operation runs and after a timeout.
- R5: A program stores the old byte ANDed with the target data and never sets a bit. It completes once the byte equals the target data.
- R6: A program that would need a 0 bit turned into 1 stays busy until `PGM_LIMIT` ticks have been counted, and then reports `rd_data_o[5]` = 1. After a reset command, the byte reads as old AND target.
- R7: After a timeout the block stays busy with `rd_data_o[5]` = 1 until `reset_cmd_i` is asserted. That pulse returns it to read mode on the next clock edge.
- R8: An erase writes 0x00 to every address before the single erase strobe. It then ends in read mode with every byte reading 0xFF.
- R9: While an erase runs, `rd_data_o[7]` reads 0 and `rd_data_o[5]` reads 0 until the limit expires.
- R10: If the erase check keeps failing, the block times out after `ERS_LIMIT` ticks with `rd_data_o[5]` = 1 and stays busy.
- R11: Programs may target any address in any order, and each one leaves the other addresses unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Accepted-command strobe from the decoder |
| op_erase_i | input | 1 | 1 = whole-array erase, 0 = byte program |
| addr_i | input | AW | Program target address |
| data_i | input | DW | Program target data |
| reset_cmd_i | input | 1 | Read/reset command; exits a timeout |
| tick_i | input | 1 | Time-base strobe for the limits |
| rd_i | input | 1 | Data read strobe |
| rd_addr_i | input | AW | Data read address |
| rd_data_o | output | DW | Array data in read mode, status byte when busy |
| busy_o | output | 1 | Operation running or timed out |
| arr_addr_o | output | AW | Array address |
| arr_wdata_o | output | DW | Array write data |
| arr_we_o | output | 1 | Array byte write |
| arr_erase_o | output | 1 | Whole-array erase strobe (all bytes to 0xFF) |
| arr_rdata_i | input | DW | Array read data for `arr_addr_o`, same cycle |

## Verification
A sequencer stuck in a running state shows up at once as `busy_o` staying high, and the polling bit never gives way to array data. A wrong target register shows up at the next status read as a wrong polling bit, or after completion as a wrong byte. A write mask that sets bits shows up on the first write as a stored bit the old byte did not have. A timer that counts wrongly moves the rise of bit 5 off the exact tick count, which the bench checks one tick early and at the limit. A skipped preprogram pass shows up at the erase strobe as a nonzero byte in the array.

// File: rtl/epc_pkg.sv
// Shared types for the embedded operation controller.
package epc_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_PGM_WR,
        S_PGM_VFY,
        S_PRE_WR,
        S_PRE_VFY,
        S_ERS_PULSE,
        S_ERS_VFY,
        S_FAIL
    } seq_state_e;
endpackage

// File: rtl/epc_timer.sv
// Operation time limit counter.
// Counts tick strobes while an operation runs and saturates at the limit.
// The limit depends on the operation type. Assumes limits are at least 1.
module epc_timer #(
    parameter int PGM_LIMIT = 8,
    parameter int ERS_LIMIT = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    input  logic erase_i,
    input  logic tick_i,
    output logic expired_o
);
    localparam int MAXL  = (PGM_LIMIT > ERS_LIMIT) ? PGM_LIMIT : ERS_LIMIT;
    localparam int CNT_W = $clog2(MAXL + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // Pick the limit that applies to the running operation.
    always_comb limit = erase_i ? CNT_W'(ERS_LIMIT) : CNT_W'(PGM_LIMIT);

    assign expired_o = (cnt >= limit);

    // Tick counter: clear at start, count while running, hold at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            cnt <= '0;
        else if (run_i && tick_i && !expired_o)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/epc_status.sv
// Status byte formatter.
// Builds the byte shown on data reads while busy: polling, toggle, timeout.
// Assumes DW >= 3.
module epc_status #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_i,
    input  logic          active_i,
    input  logic          poll_i,
    input  logic          timeout_i,
    output logic [DW-1:0] status_o
);
    logic tog;

    // Toggle bit: flips on every read strobe while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tog <= 1'b0;
        else if (rd_i && active_i)
            tog <= ~tog;
    end

    // Assemble the status byte; low bits read zero.
    always_comb begin
        status_o       = '0;
        status_o[DW-1] = poll_i;
        status_o[DW-2] = tog;
        status_o[DW-3] = timeout_i;
    end
endmodule

// File: rtl/epc_seq.sv
// Program/erase sequencer.
// Runs write-then-verify loops for programming, and a zero preprogram pass,
// erase strobe and verify scan for erase. Assumes an array whose read data
// is valid in the same cycle as the address.
module epc_seq
    import epc_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          op_erase_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    input  logic          reset_cmd_i,
    input  logic [AW-1:0] rd_addr_i,
    input  logic          expired_i,
    input  logic [DW-1:0] arr_rdata_i,
    output logic [AW-1:0] arr_addr_o,
    output logic [DW-1:0] arr_wdata_o,
    output logic          arr_we_o,
    output logic          arr_erase_o,
    output logic          clr_o,
    output logic          running_o,
    output logic          busy_o,
    output logic          failed_o,
    output logic          poll_o,
    output logic          erase_o
);
    localparam logic [AW-1:0] LAST_ADDR = {AW{1'b1}};
    localparam logic [DW-1:0] ERASED    = {DW{1'b1}};

    seq_state_e    state;
    logic [AW-1:0] tgt_addr;
    logic [DW-1:0] tgt_data;
    logic [AW-1:0] ptr;
    logic          is_erase;

    assign clr_o     = (state == S_IDLE) && start_i;
    assign running_o = (state != S_IDLE) && (state != S_FAIL);
    assign busy_o    = (state != S_IDLE);
    assign failed_o  = (state == S_FAIL);
    assign erase_o   = is_erase;
    assign poll_o    = is_erase ? 1'b0 : ~tgt_data[DW-1];

    // Array port drive for the current step.
    always_comb begin
        arr_addr_o  = rd_addr_i;
        arr_wdata_o = '0;
        arr_we_o    = 1'b0;
        arr_erase_o = 1'b0;
        case (state)
            S_PGM_WR: begin
                arr_addr_o  = tgt_addr;
                arr_wdata_o = tgt_data & arr_rdata_i;
                arr_we_o    = 1'b1;
            end
            S_PGM_VFY:   arr_addr_o = tgt_addr;
            S_PRE_WR: begin
                arr_addr_o = ptr;
                arr_we_o   = 1'b1;
            end
            S_PRE_VFY:   arr_addr_o = ptr;
            S_ERS_PULSE: arr_erase_o = 1'b1;
            S_ERS_VFY:   arr_addr_o = ptr;
            default:     ;
        endcase
    end

    // State, operands and scan pointer; timeout wins over any running step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            tgt_addr <= '0;
            tgt_data <= '0;
            ptr      <= '0;
            is_erase <= 1'b0;
        end else if (running_o && expired_i) begin
            state <= S_FAIL;
        end else begin
            case (state)
                S_IDLE: if (start_i) begin
                    tgt_addr <= addr_i;
                    tgt_data <= data_i;
                    is_erase <= op_erase_i;
                    ptr      <= '0;
                    state    <= op_erase_i ? S_PRE_WR : S_PGM_WR;
                end
                S_PGM_WR:  state <= S_PGM_VFY;
                S_PGM_VFY: state <= (arr_rdata_i == tgt_data) ? S_IDLE : S_PGM_WR;
                S_PRE_WR:  state <= S_PRE_VFY;
                S_PRE_VFY: begin
                    if (arr_rdata_i != '0) begin
                        state <= S_PRE_WR;
                    end else if (ptr == LAST_ADDR) begin
                        ptr   <= '0;
                        state <= S_ERS_PULSE;
                    end else begin
                        ptr   <= ptr + 1'b1;
                        state <= S_PRE_WR;
                    end
                end
                S_ERS_PULSE: begin
                    ptr   <= '0;
                    state <= S_ERS_VFY;
                end
                S_ERS_VFY: begin
                    if (arr_rdata_i != ERASED)
                        state <= S_ERS_PULSE;
                    else if (ptr == LAST_ADDR)
                        state <= S_IDLE;
                    else
                        ptr <= ptr + 1'b1;
                end
                S_FAIL:  if (reset_cmd_i) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/emb_op_ctrl.sv
// Embedded program/erase operation controller, top level.
// Joins the sequencer, the time limit counter and the status formatter.
// Data reads return array contents in read mode and status while busy.
module emb_op_ctrl #(
    parameter int AW        = 4,
    parameter int DW        = 8,
    parameter int PGM_LIMIT = 8,
    parameter int ERS_LIMIT = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          op_erase_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    input  logic          reset_cmd_i,
    input  logic          tick_i,
    input  logic          rd_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o,
    output logic          busy_o,
    output logic [AW-1:0] arr_addr_o,
    output logic [DW-1:0] arr_wdata_o,
    output logic          arr_we_o,
    output logic          arr_erase_o,
    input  logic [DW-1:0] arr_rdata_i
);
    logic          clr, running, failed, poll, is_erase, expired;
    logic [DW-1:0] status;

    epc_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_erase_i(op_erase_i),
        .addr_i(addr_i), .data_i(data_i), .reset_cmd_i(reset_cmd_i),
        .rd_addr_i(rd_addr_i), .expired_i(expired), .arr_rdata_i(arr_rdata_i),
        .arr_addr_o(arr_addr_o), .arr_wdata_o(arr_wdata_o), .arr_we_o(arr_we_o),
        .arr_erase_o(arr_erase_o), .clr_o(clr), .running_o(running),
        .busy_o(busy_o), .failed_o(failed), .poll_o(poll), .erase_o(is_erase)
    );

    epc_timer #(.PGM_LIMIT(PGM_LIMIT), .ERS_LIMIT(ERS_LIMIT)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .run_i(running),
        .erase_i(is_erase), .tick_i(tick_i), .expired_o(expired)
    );

    epc_status #(.DW(DW)) u_status (
        .clk(clk), .rst_n(rst_n), .rd_i(rd_i), .active_i(busy_o),
        .poll_i(poll), .timeout_i(failed), .status_o(status)
    );

    // Data read path: status while busy, array contents otherwise.
    assign rd_data_o = busy_o ? status : arr_rdata_i;
endmodule

// File: rtl/epc_chk.sv
// Port-level protocol checker for emb_op_ctrl, attached by bind.
module epc_chk #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          reset_cmd_i,
    input logic          rd_i,
    input logic [DW-1:0] rd_data_o,
    input logic          busy_o,
    input logic [DW-1:0] arr_wdata_o,
    input logic          arr_we_o,
    input logic          arr_erase_o,
    input logic [DW-1:0] arr_rdata_i
);
    // R2
    start_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && start_i |=> busy_o);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !arr_we_o && !arr_erase_o);
    // R5
    clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we_o |-> ((arr_wdata_o & ~arr_rdata_i) == '0));
    // R4
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i && busy_o |=> !busy_o || (rd_data_o[DW-2] != $past(rd_data_o[DW-2])));
    // R7
    timeout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && rd_data_o[DW-3] && !reset_cmd_i |=> busy_o && rd_data_o[DW-3]);
    // R7
    timeout_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && rd_data_o[DW-3] && reset_cmd_i |=> !busy_o);
    // R8
    one_array_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arr_we_o, arr_erase_o}));
endmodule

bind emb_op_ctrl epc_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/tb_emb_op_ctrl.sv
// Scoreboard bench for emb_op_ctrl with a behavioural array model.
module tb_emb_op_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4, DW = 8, PGM_LIMIT = 8, ERS_LIMIT = 12;
    localparam int DEPTH = 1 << AW;

    typedef struct {
        logic [DW-1:0] exp;
        logic [DW-1:0] mask;
        string         tag;
    } item_t;

    logic clk = 0, rst_n = 0, start_i = 0, op_erase_i = 0, reset_cmd_i = 0;
    logic tick_i = 0, rd_i = 0;
    logic [AW-1:0] addr_i = '0, rd_addr_i = '0;
    logic [DW-1:0] data_i = '0;
    logic [DW-1:0] rd_data_o, arr_wdata_o, arr_rdata_i;
    logic [AW-1:0] arr_addr_o;
    logic busy_o, arr_we_o, arr_erase_o;

    logic [DW-1:0] mem [DEPTH];
    logic stuck_en = 0;
    logic [AW-1:0] stuck_addr = '0;
    logic erase_seen = 0, pre_ok = 1;
    logic [DW-1:0] last_rd;
    item_t sb[$];
    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    emb_op_ctrl #(.AW(AW), .DW(DW), .PGM_LIMIT(PGM_LIMIT), .ERS_LIMIT(ERS_LIMIT)) dut (.*);

    // Array model: combinational read, clocked write and erase; optional stuck bit 0.
    assign arr_rdata_i = mem[arr_addr_o];
    initial for (int i = 0; i < DEPTH; i++) mem[i] = '1;
    always @(posedge clk) begin
        if (arr_we_o)
            mem[arr_addr_o] <= arr_wdata_o;
        if (arr_erase_o) begin
            erase_seen <= 1;
            for (int i = 0; i < DEPTH; i++) begin
                if (mem[i] != '0) pre_ok <= 0;
                mem[i] <= (stuck_en && AW'(i) == stuck_addr) ? 8'hFE : 8'hFF;
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [DW-1:0] act, exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every read strobe and compares.
    always @(negedge clk) begin
        if (rd_i) begin
            last_rd = rd_data_o;
            if (sb.size() == 0)
                chk(0, "scoreboard empty", rd_data_o, '0);
            else begin
                item_t it = sb.pop_front();
                chk(((rd_data_o ^ it.exp) & it.mask) == '0, it.tag, rd_data_o, it.exp);
            end
        end
    end

    // Driver: one read strobe with its expected value pushed first.
    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e,
                      input logic [DW-1:0] m, input string tag);
        item_t it;
        it.exp = e; it.mask = m; it.tag = tag;
        sb.push_back(it);
        rd_addr_i = a; rd_i = 1;
        @(posedge clk); #1 rd_i = 0;
    endtask

    task automatic toggle_pair(input string tag);
        logic first;
        rd(0, 0, 0, tag);
        first = last_rd[6];
        rd(0, 0, 0, tag);
        chk(last_rd[6] != first, tag, {7'b0, last_rd[6]}, {7'b0, ~first});
    endtask

    task automatic start_op(input logic er, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(posedge clk); #1 start_i = 1; op_erase_i = er; addr_i = a; data_i = d;
        @(posedge clk); #1 start_i = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_i = 1; @(posedge clk); #1 tick_i = 0; @(posedge clk); #1;
        end
    endtask

    task automatic busy_is(input logic e, input string tag);
        @(negedge clk);
        chk(busy_o == e, tag, {7'b0, busy_o}, {7'b0, e});
        @(posedge clk); #1;
    endtask

    task automatic reset_cmd();
        reset_cmd_i = 1; @(posedge clk); #1 reset_cmd_i = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        busy_is(0, "R1 idle after reset");
        rd(5, 8'hFF, 8'hFF, "R1 read mode data");

        // Program: polling bit right after start, then true data.
        start_op(0, 15, 8'h5A);
        rd(0, 8'h80, 8'hBF, "R3 polling complement");
        repeat (4) @(posedge clk); #1;
        rd(15, 8'h5A, 8'hFF, "R3 R5 programmed byte");
        start_op(0, 3, 8'h0F);
        repeat (4) @(posedge clk); #1;
        rd(3, 8'h0F, 8'hFF, "R11 lower address after higher");
        rd(15, 8'h5A, 8'hFF, "R11 other address untouched");

        // Program that needs 0->1: times out after the program limit.
        start_op(0, 3, 8'hF3);
        rd(0, 8'h00, 8'hBF, "R6 running, no timeout yet");
        toggle_pair("R4 toggle while running");
        start_op(0, 7, 8'h00);
        reset_cmd();
        busy_is(1, "R2 start and reset ignored while running");
        ticks(PGM_LIMIT - 1);
        rd(0, 8'h00, 8'hBF, "R6 one tick before limit");
        ticks(1);
        repeat (2) @(posedge clk); #1;
        rd(0, 8'h20, 8'hBF, "R6 timeout bit set");
        toggle_pair("R4 toggle after timeout");
        repeat (5) @(posedge clk); #1;
        busy_is(1, "R7 timeout held");
        reset_cmd();
        busy_is(0, "R7 reset returns to read mode");
        rd(3, 8'h03, 8'hFF, "R6 byte is old AND target");
        rd(7, 8'hFF, 8'hFF, "R2 ignored start left byte");

        // Erase: polling bit 0, zero preprogram, all ones after.
        erase_seen = 0; pre_ok = 1;
        start_op(1, 0, 8'h00);
        rd(0, 8'h00, 8'hBF, "R9 erase polling bit");
        toggle_pair("R4 toggle during erase");
        repeat (70) @(posedge clk); #1;
        chk(erase_seen && pre_ok, "R8 all zero at erase strobe", {7'b0, pre_ok}, 8'h01);
        busy_is(0, "R8 erase done");
        rd(0, 8'hFF, 8'hFF, "R8 erased addr 0");
        rd(3, 8'hFF, 8'hFF, "R8 erased addr 3");
        rd(15, 8'hFF, 8'hFF, "R8 erased addr 15");

        // Erase against a stuck bit: times out after the erase limit.
        stuck_en = 1; stuck_addr = 9;
        start_op(1, 0, 8'h00);
        repeat (70) @(posedge clk); #1;
        busy_is(1, "R10 erase still running");
        rd(0, 8'h00, 8'hBF, "R10 no timeout before limit");
        ticks(ERS_LIMIT);
        repeat (2) @(posedge clk); #1;
        rd(0, 8'h20, 8'hBF, "R10 erase timeout bit");
        busy_is(1, "R10 stays busy");
        reset_cmd();
        rd(9, 8'hFE, 8'hFF, "R7 read mode after reset");

        repeat (2) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule